// File: doc/BRIEF.md
# Initial Latency Controller for a DDR Pseudo-Static RAM Bus

This block sets how many clocks pass between the command-address phase of a transaction and its first data beat. When a transaction starts it captures the transaction type (memory or register space, read or write), a refresh-pending flag from the refresh scheduler and the latency count held in a small configuration field. It then steps through three phases: the command-address phase, the latency phase and a one-clock data-start pulse that hands control to the data path.

Memory reads, memory writes and register reads all carry an initial latency. If a refresh is pending when one of them starts, the block drives the strobe high for the whole command-address phase, and the latency phase runs for twice the programmed count. Register writes skip the latency phase entirely. Their data follows straight after command-address, and the strobe stays low for them even if a refresh is pending, because that refresh can run alongside the register capture.

Top module: `init_lat_ctrl`

## Requirements
- R1: After reset, `ca_phase_o`, `rwds_o`, `lat_phase_o` and `data_start_o` are low and `lat_clks_o` reads 6.
- R2: One clock after a `cfg_wr_i` pulse, `lat_clks_o` follows the written code: 4'hE gives 3, 4'hF gives 4, 4'h0 gives 5 and 4'h1 gives 6.
- R3: Every other code is reserved and reads back as 6 clocks.
- R4: `txn_start_i` is sampled on a clock edge. From the next cycle on, `ca_phase_o` is high for exactly CA_CLKS cycles.
- R5: A memory read, memory write or register read that starts with no refresh pending drives `rwds_o` low throughout command-address. `lat_phase_o` is then high for exactly the programmed count of cycles, starting right after command-address.
- R6: If a refresh is pending when such a transaction starts, `rwds_o` is high for every command-address cycle. `lat_phase_o` then lasts twice the programmed count. `rwds_o` is never high outside command-address.
- R7: A register write (`txn_reg_i`=1, `txn_write_i`=1) has no latency phase, and `rwds_o` stays low whatever `refresh_pend_i` is.
- R8: `data_start_o` is high for exactly one cycle. That cycle comes right after the last latency cycle, or right after the last command-address cycle for a register write.
- R9: `txn_start_i` is ignored while a transaction is still in progress.
- R10: The latency count is captured when the transaction starts. A configuration write made during a transaction affects only later transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Write strobe for the latency code field |
| cfg_code_i | input | 4 | Latency code to write |
| txn_start_i | input | 1 | Start of a transaction, one-cycle pulse |
| txn_reg_i | input | 1 | 1 = register space, 0 = memory space |
| txn_write_i | input | 1 | 1 = write, 0 = read |
| refresh_pend_i | input | 1 | A distributed refresh is pending |
| lat_clks_o | output | 3 | Programmed latency count, in clocks |
| ca_phase_o | output | 1 | Command-address phase in progress |
| rwds_o | output | 1 | Strobe level to drive during command-address |
| lat_phase_o | output | 1 | Latency phase in progress |
| data_start_o | output | 1 | One-cycle pulse that starts the data phase |

## Verification
The bench targets the refresh-doubled latency for each transaction type and a register write that arrives with a refresh pending. A design that treated register writes like other transactions would raise the strobe for them or insert latency. The reserved and edge codes catch a decoder that falls through to the wrong count. A start pulse injected during a busy transaction and a configuration write made mid-transaction expose a sequencer that restarts, or one that reads the live field instead of the captured one; either fault moves the data-start pulse off its expected cycle.

// File: rtl/init_lat_ctrl_pkg.sv
package init_lat_ctrl_pkg;
  localparam int unsigned LAT_W   = 3;
  localparam int unsigned MIN_LAT = 3;
  localparam int unsigned MAX_LAT = 6;
  localparam int unsigned CODE_W  = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_CA, ST_LAT, ST_DATA} lat_st_e;

  // latency field code -> clocks; reserved codes fall back to the slowest
  function automatic logic [LAT_W-1:0] lat_decode(input logic [CODE_W-1:0] code);
    logic [LAT_W-1:0] clks;
    case (code)
      4'hE:    clks = 3'd3;
      4'hF:    clks = 3'd4;
      4'h0:    clks = 3'd5;
      default: clks = 3'd6;
    endcase
    return clks;
  endfunction
endpackage

// File: rtl/init_lat_cfg.sv
module init_lat_cfg
  import init_lat_ctrl_pkg::*;
#(
  parameter logic [CODE_W-1:0] RST_CODE = 4'h1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [LAT_W-1:0]  lat_clks_o
);
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   code_q <= RST_CODE;
    else if (wr_i) code_q <= code_i;
  end

  assign lat_clks_o = lat_decode(code_q);
endmodule

// File: rtl/init_lat_seq.sv
module init_lat_seq
  import init_lat_ctrl_pkg::*;
#(
  parameter int unsigned CA_CLKS = 3,
  localparam int unsigned SPAN   = (CA_CLKS > 2*MAX_LAT) ? CA_CLKS : 2*MAX_LAT,
  localparam int unsigned CNT_W  = $clog2(SPAN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             is_reg_i,
  input  logic             is_wr_i,
  input  logic             refresh_i,
  input  logic [LAT_W-1:0] lat_clks_i,
  output logic             ca_o,
  output logic             rwds_o,
  output logic             lat_o,
  output logic             data_o
);
  lat_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] tot_q;
  logic [CNT_W-1:0] tot_d;
  logic             bypass_q;
  logic             extra_q;
  logic             reg_wr;

  assign reg_wr = is_reg_i & is_wr_i;

  always_comb begin
    tot_d = CNT_W'(lat_clks_i);
    if (refresh_i) tot_d = tot_d << 1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      tot_q    <= '0;
      bypass_q <= 1'b0;
      extra_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q     <= ST_CA;
          cnt_q    <= CNT_W'(CA_CLKS - 1);
          tot_q    <= tot_d;
          bypass_q <= reg_wr;
          extra_q  <= refresh_i & ~reg_wr;
        end
        ST_CA: begin
          if (cnt_q == '0) begin
            st_q  <= bypass_q ? ST_DATA : ST_LAT;
            cnt_q <= tot_q - CNT_W'(1);
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_LAT: begin
          if (cnt_q == '0) st_q <= ST_DATA;
          else             cnt_q <= cnt_q - CNT_W'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ca_o   = (st_q == ST_CA);
  assign rwds_o = (st_q == ST_CA) & extra_q;
  assign lat_o  = (st_q == ST_LAT);
  assign data_o = (st_q == ST_DATA);
endmodule

// File: rtl/init_lat_ctrl.sv
module init_lat_ctrl
  import init_lat_ctrl_pkg::*;
#(
  parameter int unsigned CA_CLKS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [CODE_W-1:0] cfg_code_i,
  input  logic              txn_start_i,
  input  logic              txn_reg_i,
  input  logic              txn_write_i,
  input  logic              refresh_pend_i,
  output logic [LAT_W-1:0]  lat_clks_o,
  output logic              ca_phase_o,
  output logic              rwds_o,
  output logic              lat_phase_o,
  output logic              data_start_o
);
  init_lat_cfg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (cfg_wr_i),
    .code_i     (cfg_code_i),
    .lat_clks_o (lat_clks_o)
  );

  init_lat_seq #(.CA_CLKS(CA_CLKS)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (txn_start_i),
    .is_reg_i   (txn_reg_i),
    .is_wr_i    (txn_write_i),
    .refresh_i  (refresh_pend_i),
    .lat_clks_i (lat_clks_o),
    .ca_o       (ca_phase_o),
    .rwds_o     (rwds_o),
    .lat_o      (lat_phase_o),
    .data_o     (data_start_o)
  );
endmodule

// File: rtl/init_lat_ctrl_chk.sv
module init_lat_ctrl_chk
  import init_lat_ctrl_pkg::*;
#(
  parameter int unsigned CA_CLKS = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LAT_W-1:0] lat_clks_o,
  input logic             ca_phase_o,
  input logic             rwds_o,
  input logic             lat_phase_o,
  input logic             data_start_o
);
  logic [7:0] ca_run_q, lat_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ca_run_q  <= '0;
      lat_run_q <= '0;
    end else begin
      ca_run_q  <= ca_phase_o  ? ca_run_q + 8'd1  : 8'd0;
      lat_run_q <= lat_phase_o ? lat_run_q + 8'd1 : 8'd0;
    end
  end

  AST_CFG_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_clks_o >= LAT_W'(MIN_LAT)) && (lat_clks_o <= LAT_W'(MAX_LAT))); // R3
  AST_CA_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ca_phase_o) |-> (ca_run_q == 8'(CA_CLKS))); // R4
  AST_RWDS_IN_CA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rwds_o |-> ca_phase_o); // R6
  AST_RWDS_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ca_phase_o && $past(ca_phase_o)) |-> $stable(rwds_o)); // R6
  AST_LAT_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lat_phase_o) |-> (lat_run_q >= 8'(MIN_LAT) && lat_run_q <= 8'(2*MAX_LAT))); // R5
  AST_LAT_TO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lat_phase_o) |-> data_start_o); // R8
  AST_DATA_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_start_o |=> !data_start_o); // R8
  AST_PHASE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ca_phase_o, lat_phase_o, data_start_o})); // R9
endmodule

bind init_lat_ctrl init_lat_ctrl_chk #(.CA_CLKS(CA_CLKS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lat_clks_o   (lat_clks_o),
  .ca_phase_o   (ca_phase_o),
  .rwds_o       (rwds_o),
  .lat_phase_o  (lat_phase_o),
  .data_start_o (data_start_o)
);

// File: tb/init_lat_ctrl_tb.sv
`timescale 1ns/1ps
module init_lat_ctrl_tb;
  localparam int CA = 3;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cfg_wr = 1'b0, txn_start = 1'b0, txn_reg = 1'b0, txn_wr = 1'b0, ref_p = 1'b0;
  logic [3:0] cfg_code = 4'h0;
  logic [2:0] lat_clks;
  logic       ca, rwds, lat, dstart;
  int         errors = 0, checks = 0;
  int         exp_lat = 6;

  always #2.5 clk = ~clk;

  init_lat_ctrl #(.CA_CLKS(CA)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_code_i(cfg_code),
    .txn_start_i(txn_start), .txn_reg_i(txn_reg), .txn_write_i(txn_wr),
    .refresh_pend_i(ref_p), .lat_clks_o(lat_clks), .ca_phase_o(ca),
    .rwds_o(rwds), .lat_phase_o(lat), .data_start_o(dstart));

  function automatic int ref_decode(input logic [3:0] c);
    case (c)
      4'hE: return 3;
      4'hF: return 4;
      4'h0: return 5;
      default: return 6;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [3:0] c, input string req);
    @(negedge clk); cfg_wr = 1'b1; cfg_code = c;
    @(negedge clk); cfg_wr = 1'b0;
    exp_lat = ref_decode(c);
    check(req, int'(lat_clks), exp_lat);
  endtask

  // busy_kick: extra start mid-transaction (R9); mid_cfg: config write mid-transaction (R10)
  task automatic run_txn(input bit is_reg, input bit is_wr, input bit rf,
                         input bit busy_kick, input bit mid_cfg, input logic [3:0] mcode);
    int n_ca = 0, n_rw = 0, n_rw_out = 0, n_lat = 0, n_data = 0, k_data = 0;
    int exp_n;
    bit bypass = is_reg && is_wr;
    exp_n = bypass ? 0 : (rf ? 2*exp_lat : exp_lat);
    @(negedge clk);
    txn_start = 1'b1; txn_reg = is_reg; txn_wr = is_wr; ref_p = rf;
    @(negedge clk);
    txn_start = 1'b0; ref_p = $urandom_range(0, 1);
    for (int k = 1; k <= 24; k++) begin
      if (ca) n_ca++;
      if (rwds && ca) n_rw++;
      if (rwds && !ca) n_rw_out++;
      if (lat) n_lat++;
      if (dstart) begin n_data++; if (k_data == 0) k_data = k; end
      txn_start = busy_kick && (k == 2);
      cfg_wr = mid_cfg && (k == 2);
      cfg_code = mcode;
      @(negedge clk);
    end
    txn_start = 1'b0; cfg_wr = 1'b0;
    if (mid_cfg) exp_lat = ref_decode(mcode);
    check("R4 ca cycles", n_ca, CA);
    check(bypass ? "R7 rwds in ca" : (rf ? "R6 rwds in ca" : "R5 rwds in ca"),
          n_rw, (rf && !bypass) ? CA : 0);
    check("R6 rwds outside ca", n_rw_out, 0);
    check(bypass ? "R7 lat cycles" : (rf ? "R6 lat cycles" : "R5 lat cycles"), n_lat, exp_n);
    check("R8 data pulse count", n_data, 1);
    check(busy_kick ? "R9 data position" : (mid_cfg ? "R10 data position" : "R8 data position"),
          k_data, CA + exp_n + 1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    #12 rst_n = 1'b1;
    @(negedge clk);
    check("R1 ca", int'(ca), 0);
    check("R1 rwds", int'(rwds), 0);
    check("R1 lat", int'(lat), 0);
    check("R1 data", int'(dstart), 0);
    check("R1 lat_clks", int'(lat_clks), 6);
    write_cfg(4'hE, "R2 code E");
    write_cfg(4'hF, "R2 code F");
    write_cfg(4'h0, "R2 code 0");
    write_cfg(4'h1, "R2 code 1");
    write_cfg(4'h7, "R3 code 7");
    write_cfg(4'hD, "R3 code D");
    write_cfg(4'hE, "R2 code E");
    run_txn(0, 0, 0, 0, 0, 4'h0);
    run_txn(0, 1, 1, 0, 0, 4'h0);
    run_txn(1, 0, 1, 0, 0, 4'h0);
    run_txn(1, 1, 1, 0, 0, 4'h0);
    run_txn(1, 1, 0, 0, 0, 4'h0);
    run_txn(0, 0, 1, 1, 0, 4'h0);
    run_txn(0, 1, 0, 0, 1, 4'h1);
    run_txn(1, 0, 1, 0, 0, 4'h0);
    for (int i = 0; i < 40; i++) begin
      if ($urandom_range(0, 3) == 0)
        write_cfg(4'($urandom_range(0, 15)), "R2 random code");
      run_txn(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule